// File: doc/BRIEF.md
# Interrupt eligibility and priority arbiter

This block decides, for a single processor interface, which interrupt should be presented next. It takes per-interrupt state vectors for 32 private interrupts (IDs 0 to 31) and `NUM_SHARED` shared interrupts (IDs from 32 upward). The vectors are a pending latch, an edge/level configuration, the input level, enable, active, group and group-modifier bits, an 8-bit priority for each interrupt, and a routing mask that says whether each shared interrupt targets this interface. A 4-bit control word supplies three group enables and a security-disable override.

A one-cycle `start` pulse launches a scan. The scan walks the vectors one 32-interrupt word per clock, keeps a running best candidate, and at the end loads the winning ID, its priority and its group class into the result registers together with a one-cycle `done` strobe. The result registers hold their value between scans. The caller keeps the input vectors steady from the start pulse until `done`.

Top module: `irq_arbiter`

## Requirements
- R1: An interrupt is pending when its pending latch is 1, or when its edge-configuration bit is 0 (level-sensitive) and its input level is 1.
- R2: A pending interrupt is eligible only when its enable bit is 1 and its active bit is 0.
- R3: Group bit 1 gives class 2 (non-secure group 1), gated by ctrl[2]. Group bit 0 with modifier 1 gives class 1 (secure group 1), gated by ctrl[1]. Group bit 0 with modifier 0 gives class 0 (group 0), gated by ctrl[0]. The class of the winner appears on `cls_o`.
- R4: When ctrl[3] (security disable) is 1, every modifier bit is taken as 0.
- R5: Among eligible interrupts, the numerically lowest priority value wins. An interrupt whose priority is 0xFF is never selected.
- R6: Among eligible interrupts of equal priority, the one with the lowest ID wins.
- R7: When no interrupt is selected, the result is priority 0xFF, ID 0 and class 0. This is also the result state after reset.
- R8: Shared interrupt i (ID 32+i) is eligible only when `route_ok[i]` is 1. Private interrupts ignore `route_ok`.
- R9: `done_o` pulses for one cycle on the NW-th rising edge after the edge that samples `start`, where NW = (32+NUM_SHARED)/32. The result outputs change only on that edge.
- R10: A `start` pulse during a scan restarts it from word 0 with the running best cleared. Only the restarted scan produces `done_o` and a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) a scan |
| pend_latch | input | 32+NUM_SHARED | Pending latch per interrupt |
| edge_cfg | input | 32+NUM_SHARED | 1 = edge-triggered, 0 = level-sensitive |
| line_lvl | input | 32+NUM_SHARED | Current input level per interrupt |
| enable | input | 32+NUM_SHARED | Enable per interrupt |
| active | input | 32+NUM_SHARED | Active state per interrupt |
| group | input | 32+NUM_SHARED | Group bit per interrupt |
| grp_mod | input | 32+NUM_SHARED | Group modifier per interrupt |
| prio | input | 8*(32+NUM_SHARED) | Priority of ID k at bits [8k+7:8k] |
| route_ok | input | NUM_SHARED | Routing-valid bit for shared interrupt 32+i at bit i |
| ctrl | input | 4 | [0] group 0 enable, [1] secure group 1 enable, [2] non-secure group 1 enable, [3] security disable |
| done_o | output | 1 | One-cycle end-of-scan strobe |
| id_o | output | clog2(32+NUM_SHARED) | Winning interrupt ID |
| prio_o | output | 8 | Winning priority, 0xFF when none |
| cls_o | output | 2 | Winning group class (0, 1, 2) |

## Verification
The assertions check on every cycle that a restart clears the scan state, that the running best priority never gets worse during a scan, that `done_o` follows only a running scan, that the results stay unchanged except on a done edge, and that an empty result carries ID 0 and class 0. The eligibility rules cannot be checked by an assertion. These are the pending formula, the three-way group gating, the security override, the routing mask, the lowest-ID tie break and the exclusion of priority 0xFF. The bench's scenarios show them through exhaustive sweeps of control words and group bits, of the pending and enable inputs, and through random multi-interrupt patterns compared against an arithmetic model.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_SHARED = 64,
  localparam int NI  = 32 + NUM_SHARED,
  localparam int NW  = NI / 32,
  localparam int WW  = (NW > 1) ? $clog2(NW) : 1,
  localparam int IDW = $clog2(NI)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NI-1:0]   pend_latch,
  input  logic [NI-1:0]   edge_cfg,
  input  logic [NI-1:0]   line_lvl,
  input  logic [NI-1:0]   enable,
  input  logic [NI-1:0]   active,
  input  logic [NI-1:0]   group,
  input  logic [NI-1:0]   grp_mod,
  input  logic [8*NI-1:0] prio,
  input  logic [NUM_SHARED-1:0] route_ok,
  input  logic [3:0]      ctrl,
  output logic            done_o,
  output logic [IDW-1:0]  id_o,
  output logic [7:0]      prio_o,
  output logic [1:0]      cls_o
);

  logic           busy;
  logic [WW-1:0]  widx;
  logic [7:0]     bprio, cprio;
  logic [IDW-1:0] bid, cid;
  logic [1:0]     bcls, ccls;
  logic [NI-1:0]  rvec;
  logic           last;

  assign rvec = {route_ok, 32'hFFFF_FFFF};
  assign last = (int'(widx) == NW - 1);

  always_comb begin
    int k;
    logic md, gen, ok;
    logic [7:0] p;
    cprio = bprio;
    cid   = bid;
    ccls  = bcls;
    for (int j = 0; j < 32; j++) begin
      k   = int'(widx) * 32 + j;
      md  = grp_mod[k] & ~ctrl[3];
      gen = group[k] ? ctrl[2] : (md ? ctrl[1] : ctrl[0]);
      ok  = (pend_latch[k] | (~edge_cfg[k] & line_lvl[k])) & enable[k] & ~active[k] & gen & rvec[k];
      p   = prio[k*8 +: 8];
      if (ok && p < cprio) begin
        cprio = p;
        cid   = IDW'(k);
        ccls  = group[k] ? 2'd2 : {1'b0, md};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      widx   <= '0;
      bprio  <= 8'hFF;
      bid    <= '0;
      bcls   <= 2'd0;
      done_o <= 1'b0;
      prio_o <= 8'hFF;
      id_o   <= '0;
      cls_o  <= 2'd0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        widx  <= '0;
        bprio <= 8'hFF;
        bid   <= '0;
        bcls  <= 2'd0;
      end else if (busy) begin
        bprio <= cprio;
        bid   <= cid;
        bcls  <= ccls;
        if (last) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
          prio_o <= cprio;
          id_o   <= cid;
          cls_o  <= ccls;
        end else begin
          widx <= widx + 1'b1;
        end
      end
    end
  end

  AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && widx == '0 && bprio == 8'hFF); // R10
  AST_BEST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> bprio <= $past(bprio)); // R5
  AST_DONE_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy) && !$past(start)); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(prio_o) && $stable(id_o) && $stable(cls_o)); // R9
  AST_EMPTY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    prio_o == 8'hFF |-> id_o == '0 && cls_o == 2'd0); // R7

endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  localparam int NS  = 64;
  localparam int NI  = 32 + NS;
  localparam int NW  = NI / 32;
  localparam int IDW = $clog2(NI);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NI-1:0] pend_latch, edge_cfg, line_lvl, enable, active, group, grp_mod;
  logic [8*NI-1:0] prio;
  logic [NS-1:0] route_ok;
  logic [3:0] ctrl;
  logic done_o;
  logic [IDW-1:0] id_o;
  logic [7:0] prio_o;
  logic [1:0] cls_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irq_arbiter #(.NUM_SHARED(NS)) u_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pend_latch(pend_latch), .edge_cfg(edge_cfg), .line_lvl(line_lvl),
    .enable(enable), .active(active), .group(group), .grp_mod(grp_mod),
    .prio(prio), .route_ok(route_ok), .ctrl(ctrl),
    .done_o(done_o), .id_o(id_o), .prio_o(prio_o), .cls_o(cls_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    pend_latch = '0; edge_cfg = '1; line_lvl = '0; enable = '0; active = '0;
    group = '0; grp_mod = '0; prio = '1; route_ok = '1; ctrl = 4'b0111;
  endtask

  task automatic put(int id, logic [7:0] p);
    pend_latch[id] = 1'b1; enable[id] = 1'b1; prio[id*8 +: 8] = p;
  endtask

  function automatic logic [31:0] model();
    logic [7:0] bp = 8'hFF;
    int bi = 0;
    int bc = 0;
    for (int k = 0; k < NI; k++) begin
      logic md, gen, ok;
      md  = grp_mod[k] & ~ctrl[3];
      gen = group[k] ? ctrl[2] : (md ? ctrl[1] : ctrl[0]);
      ok  = (pend_latch[k] | (~edge_cfg[k] & line_lvl[k])) & enable[k] & ~active[k] & gen
            & ((k < 32) || route_ok[k-32]);
      if (ok && prio[k*8 +: 8] < bp) begin
        bp = prio[k*8 +: 8];
        bi = k;
        bc = group[k] ? 2 : (md ? 1 : 0);
      end
    end
    return {14'd0, bp, IDW'(bi), 2'(bc)} & 32'h3_FFFF;
  endfunction

  task automatic scan(output int lat);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run(string req);
    int lat;
    scan(lat);
    chk(req, {14'd0, prio_o, id_o, cls_o}, model());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    clear_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset result", {14'd0, prio_o, id_o, cls_o}, {14'd0, 8'hFF, 7'd0, 2'd0});
    chk("R9 reset done", 32'(done_o), 32'd0);

    // R3 R4: class and gating sweep on one shared interrupt
    for (int g = 0; g < 4; g++)
      for (int c = 0; c < 16; c++) begin
        clear_all();
        put(40, 8'h10);
        group[40] = g[1]; grp_mod[40] = g[0]; ctrl = 4'(c);
        run("R3 R4 group gating");
      end

    // R1 R2: pending formula and enable/active
    for (int v = 0; v < 32; v++) begin
      clear_all();
      prio[5*8 +: 8] = 8'h30;
      pend_latch[5] = v[0]; edge_cfg[5] = v[1]; line_lvl[5] = v[2];
      enable[5] = v[3]; active[5] = v[4];
      run("R1 R2 pending and enable");
    end

    // R8: routing mask
    clear_all(); put(70, 8'h04); route_ok[38] = 1'b0;
    run("R8 unrouted shared");
    chk("R8 unrouted gives none", 32'(prio_o), 32'hFF);
    route_ok[38] = 1'b1;
    run("R8 routed shared");
    chk("R8 routed id", 32'(id_o), 32'd70);
    clear_all(); put(3, 8'h08); route_ok = '0;
    run("R8 private ignores mask");
    chk("R8 private id", 32'(id_o), 32'd3);

    // R6: ties
    clear_all(); put(10, 8'h20); put(33, 8'h20); put(95, 8'h20);
    run("R6 tie");
    chk("R6 tie lowest", 32'(id_o), 32'd10);
    enable[10] = 1'b0;
    run("R6 tie next");
    chk("R6 tie next lowest", 32'(id_o), 32'd33);

    // R5: lower value wins, 0xFF never selected
    clear_all(); put(2, 8'h05); put(90, 8'h01);
    run("R5 lower wins");
    chk("R5 winner id", 32'(id_o), 32'd90);
    clear_all(); put(7, 8'hFF);
    run("R5 FF excluded");
    chk("R7 none", {14'd0, prio_o, id_o, cls_o}, {14'd0, 8'hFF, 7'd0, 2'd0});

    // R9: latency, single pulse, hold
    clear_all(); put(50, 8'h11);
    scan(lat);
    chk("R9 latency", 32'(lat), 32'(NW));
    @(negedge clk);
    chk("R9 single pulse", 32'(done_o), 32'd0);
    clear_all(); put(1, 8'h00);
    repeat (4) @(negedge clk);
    chk("R9 result held", {14'd0, prio_o, id_o, cls_o}, {14'd0, 8'h11, 7'd50, 2'd0});

    // R10: restart mid scan
    clear_all(); put(4, 8'h00);
    start = 1'b1; @(negedge clk); start = 1'b0;
    @(negedge clk);
    clear_all();
    scan(lat);
    chk("R10 restart latency", 32'(lat), 32'(NW));
    chk("R10 restart result", {14'd0, prio_o, id_o, cls_o}, model());

    // random patterns
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < NI; k++) begin
        logic [31:0] r;
        r = $urandom;
        pend_latch[k] = r[0]; edge_cfg[k] = r[1]; line_lvl[k] = r[2];
        enable[k] = r[3] | r[4]; active[k] = r[5] & r[6]; group[k] = r[7];
        grp_mod[k] = r[8]; prio[k*8 +: 8] = {r[9], 5'd0, r[11:10]};
        if (k >= 32) route_ok[k-32] = r[12] | r[13];
      end
      ctrl = 4'($urandom);
      run("R5 R6 random");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule